// File: doc/BRIEF.md
# Line Packet Framer

This block sits behind a binary phase demodulator on a power-line receiver. It takes one recovered bit per strobe and finds packets in that stream. First it looks for a run of alternating bits, which is the preamble. Once the run is long enough, it looks for a short word-sync pattern. That pattern marks where the payload begins and tells the framer whether the line has flipped the polarity of the bits.

After word sync, the framer cuts the bit stream into eleven-bit codewords. Each codeword is eight data bits (most significant first), one even-parity bit and two stop bits, all written here after polarity correction. Every accepted codeword produces one byte strobe, together with a parity-error flag. A zero stop bit ends the frame.

A busy indication is high whenever the framer is outside its idle hunt state. A local transmitter can use it to hold off while another node's preamble or packet is on the line. An external end-of-packet or abort input returns the framer to the hunt at any time.

The controller has four states:
- HUNT: idle, counting alternating bits.
- PREAMBLE: an alternating run of at least four bits has been seen.
- WORDSYNC: the preamble has reached twelve bits and the framer is searching for the sync word.
- DATA: the framer is assembling codewords.

The transitions between them are:
- HUNT to PREAMBLE: the alternating run reaches 4.
- PREAMBLE to HUNT: a repeated bit arrives.
- PREAMBLE to WORDSYNC: the run reaches 12.
- WORDSYNC to DATA: the sync word is found, in true or inverted form.
- WORDSYNC to HUNT: no sync word is found within 16 bits.
- DATA to HUNT: a stop bit is zero.
- Any state to HUNT: the end-of-packet input is asserted.

Top module: `line_pkt_framer`

## Requirements
- R1: After reset, chan_busy, byte_vld, byte_par_err, frame_err and pol_inv are all 0.
- R2: The alternating-run length counts consecutive strobed bits, each differing from the one before, since reset or the last abort, and saturates at 12. When it reaches 4 in HUNT, chan_busy rises in the cycle after that strobe.
- R3: In PREAMBLE, a bit equal to the previous bit returns the framer to HUNT, and chan_busy falls.
- R4: The sync word is searched for only after the run has reached 12. A 1100 pattern that breaks a shorter run starts no frame.
- R5: In WORDSYNC, the last four bits (oldest first) equal to 1100 enter DATA with pol_inv=0. Equal to 0011, they enter DATA with pol_inv=1, and every later codeword bit is inverted before use. pol_inv changes only on a bit strobe.
- R6: If 16 bits pass in WORDSYNC without a sync word, the framer returns to HUNT after the 16th bit.
- R7: A codeword is 8 data bits MSB first, then a parity bit making the 9 bits even, then two stop bits equal to 1. After the 11th bit, byte_vld pulses for one cycle with byte_data holding the byte.
- R8: byte_par_err is high together with byte_vld when the nine data and parity bits have odd parity. It is never high without byte_vld.
- R9: A stop bit of 0 pulses frame_err for one cycle, emits no byte and returns to HUNT. frame_err and byte_vld are never high together.
- R10: pkt_end returns the framer to HUNT in the next cycle from any state, discards any partial codeword and restarts the run count.
- R11: chan_busy is high exactly when the framer is not in HUNT.
- R12: Codewords follow one another with no gap bits, and the framer stays in DATA after each good codeword.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_vld | input | 1 | Strobe: bit_in holds a new demodulated bit |
| bit_in | input | 1 | Demodulated bit |
| pkt_end | input | 1 | End-of-packet / abort, returns to HUNT |
| byte_data | output | 8 | Last decoded byte |
| byte_vld | output | 1 | One-cycle strobe for a decoded byte |
| byte_par_err | output | 1 | Parity mismatch for the strobed byte |
| frame_err | output | 1 | One-cycle pulse on a bad stop bit |
| chan_busy | output | 1 | Framer is not idle, so the channel is in use |
| pol_inv | output | 1 | Payload was received inverted |

## Verification
The bench targets the boundaries of the sync search:
- A run that is one bit short of the busy threshold. A design that counts off by one raises busy a bit early or late.
- A 1100 pattern inside a short preamble. A framer that searches for the sync word too early would open a false frame.
- The sixteenth bit of the sync-word timeout. Getting this wrong either keeps the framer waiting forever or drops a valid late sync.
- Inverted sync, back-to-back codewords, parity flips, zero stop bits and aborts in the middle of a codeword. These are mixed in random packets, so an error in polarity handling, bit order or codeword counting shows up as wrong bytes or as strobes that are missing or extra.

// File: rtl/pkfr_pkg.sv
package pkfr_pkg;

    typedef enum logic [1:0] {
        ST_HUNT     = 2'd0,
        ST_PREAMBLE = 2'd1,
        ST_WORDSYNC = 2'd2,
        ST_DATA     = 2'd3
    } pkfr_state_e;

    localparam int          SYNC_WORD_LEN = 4;
    localparam logic [3:0]  SYNC_WORD_DEF = 4'b1100;

endpackage

// File: rtl/pkfr_run_track.sv
// Length of the current run of alternating bits, including the bit being strobed.
module pkfr_run_track #(
    parameter int RUN_MAX = 12,
    localparam int RW = $clog2(RUN_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bit_vld,
    input  logic          bit_in,
    input  logic          clr,
    output logic [RW-1:0] run_next
);

    logic [RW-1:0] run_q;
    logic          prev_q;
    logic          have_q;

    always_comb begin
        if (have_q && (bit_in != prev_q)) begin
            run_next = (run_q == RW'(RUN_MAX)) ? run_q : run_q + 1'b1;
        end else begin
            run_next = RW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            run_q  <= '0;
            prev_q <= 1'b0;
            have_q <= 1'b0;
        end else if (bit_vld) begin
            run_q  <= run_next;
            prev_q <= bit_in;
            have_q <= 1'b1;
        end
    end

endmodule

// File: rtl/pkfr_wsync.sv
// Sliding window over the last received bits, compared with the sync word and its complement.
module pkfr_wsync #(
    parameter int                 WS_LEN = 4,
    parameter logic [WS_LEN-1:0]  WS_PAT = 4'b1100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_vld,
    input  logic bit_in,
    output logic hit_true,
    output logic hit_inv
);

    logic [WS_LEN-1:0] win_q;
    logic [WS_LEN-1:0] win_next;

    assign win_next = {win_q[WS_LEN-2:0], bit_in};
    assign hit_true = bit_vld && (win_next == WS_PAT);
    assign hit_inv  = bit_vld && (win_next == ~WS_PAT);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q <= '0;
        end else if (bit_vld) begin
            win_q <= win_next;
        end
    end

endmodule

// File: rtl/pkfr_cw_asm.sv
// Codeword assembler: data bits, then the parity bit, then the stop bits.
module pkfr_cw_asm #(
    parameter int DATA_BITS = 8,
    parameter int STOP_BITS = 2,
    localparam int CW_LEN = DATA_BITS + 1 + STOP_BITS,
    localparam int IW = $clog2(CW_LEN)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 take,
    input  logic                 dbit,
    output logic [DATA_BITS-1:0] byte_o,
    output logic                 par_bad,
    output logic                 word_ok,
    output logic                 stop_bad
);

    logic [IW-1:0]        idx_q;
    logic [DATA_BITS-1:0] sh_q;
    logic                 par_q;
    logic                 in_stop;
    logic                 last;

    assign in_stop  = idx_q > IW'(DATA_BITS);
    assign last     = idx_q == IW'(CW_LEN - 1);
    assign stop_bad = take && in_stop && !dbit;
    assign word_ok  = take && last && dbit;
    assign byte_o   = sh_q;
    assign par_bad  = par_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
            sh_q  <= '0;
            par_q <= 1'b0;
        end else if (clr) begin
            idx_q <= '0;
            par_q <= 1'b0;
        end else if (take) begin
            if (idx_q < IW'(DATA_BITS)) begin
                sh_q <= {sh_q[DATA_BITS-2:0], dbit};
            end
            if (last) begin
                idx_q <= '0;
                par_q <= 1'b0;
            end else begin
                idx_q <= idx_q + 1'b1;
                if (idx_q <= IW'(DATA_BITS)) begin
                    par_q <= par_q ^ dbit;
                end
            end
        end
    end

endmodule

// File: rtl/line_pkt_framer.sv
module line_pkt_framer
    import pkfr_pkg::*;
#(
    parameter int BUSY_BITS = 4,
    parameter int SYNC_BITS = 12,
    parameter int WS_LIMIT  = 16,
    parameter int DATA_BITS = 8,
    parameter int STOP_BITS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bit_vld,
    input  logic                 bit_in,
    input  logic                 pkt_end,
    output logic [DATA_BITS-1:0] byte_data,
    output logic                 byte_vld,
    output logic                 byte_par_err,
    output logic                 frame_err,
    output logic                 chan_busy,
    output logic                 pol_inv
);

    localparam int RW = $clog2(SYNC_BITS + 1);
    localparam int WW = $clog2(WS_LIMIT);

    pkfr_state_e          state_q, state_d;
    logic [WW-1:0]        ws_cnt_q, ws_cnt_d;
    logic                 inv_q, inv_d;
    logic [RW-1:0]        run_next;
    logic                 hit_true, hit_inv;
    logic                 take, cw_clr, dbit;
    logic [DATA_BITS-1:0] cw_byte;
    logic                 cw_par_bad, cw_ok, cw_stop_bad;

    assign dbit   = bit_in ^ inv_q;
    assign take   = bit_vld && !pkt_end && (state_q == ST_DATA);
    assign cw_clr = pkt_end || (state_q != ST_DATA);

    pkfr_run_track #(.RUN_MAX(SYNC_BITS)) u_run (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_vld  (bit_vld),
        .bit_in   (bit_in),
        .clr      (pkt_end),
        .run_next (run_next)
    );

    pkfr_wsync #(.WS_LEN(SYNC_WORD_LEN), .WS_PAT(SYNC_WORD_DEF)) u_ws (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_vld  (bit_vld),
        .bit_in   (bit_in),
        .hit_true (hit_true),
        .hit_inv  (hit_inv)
    );

    pkfr_cw_asm #(.DATA_BITS(DATA_BITS), .STOP_BITS(STOP_BITS)) u_cw (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (cw_clr),
        .take     (take),
        .dbit     (dbit),
        .byte_o   (cw_byte),
        .par_bad  (cw_par_bad),
        .word_ok  (cw_ok),
        .stop_bad (cw_stop_bad)
    );

    // next state
    always_comb begin
        state_d  = state_q;
        ws_cnt_d = ws_cnt_q;
        inv_d    = inv_q;
        if (pkt_end) begin
            state_d = ST_HUNT;
        end else if (bit_vld) begin
            unique case (state_q)
                ST_HUNT: begin
                    if (run_next >= RW'(BUSY_BITS)) state_d = ST_PREAMBLE;
                end
                ST_PREAMBLE: begin
                    if (run_next == RW'(1)) begin
                        state_d = ST_HUNT;
                    end else if (run_next >= RW'(SYNC_BITS)) begin
                        state_d  = ST_WORDSYNC;
                        ws_cnt_d = '0;
                    end
                end
                ST_WORDSYNC: begin
                    if (hit_true) begin
                        state_d = ST_DATA;
                        inv_d   = 1'b0;
                    end else if (hit_inv) begin
                        state_d = ST_DATA;
                        inv_d   = 1'b1;
                    end else if (ws_cnt_q == WW'(WS_LIMIT - 1)) begin
                        state_d = ST_HUNT;
                    end else begin
                        ws_cnt_d = ws_cnt_q + 1'b1;
                    end
                end
                ST_DATA: begin
                    if (cw_stop_bad) state_d = ST_HUNT;
                end
                default: state_d = ST_HUNT;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_HUNT;
            ws_cnt_q <= '0;
            inv_q    <= 1'b0;
        end else begin
            state_q  <= state_d;
            ws_cnt_q <= ws_cnt_d;
            inv_q    <= inv_d;
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_data    <= '0;
            byte_vld     <= 1'b0;
            byte_par_err <= 1'b0;
            frame_err    <= 1'b0;
        end else begin
            byte_vld     <= cw_ok;
            byte_par_err <= cw_ok && cw_par_bad;
            frame_err    <= cw_stop_bad;
            if (cw_ok) byte_data <= cw_byte;
        end
    end

    assign chan_busy = (state_q != ST_HUNT);
    assign pol_inv   = inv_q;

endmodule

// File: rtl/pkfr_checker.sv
module pkfr_checker (
    input logic clk,
    input logic rst_n,
    input logic bit_vld,
    input logic pkt_end,
    input logic byte_vld,
    input logic byte_par_err,
    input logic frame_err,
    input logic chan_busy,
    input logic pol_inv
);

    // R9
    byte_vs_ferr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(byte_vld && frame_err));

    // R9
    ferr_drops_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |-> !chan_busy);

    // R10
    abort_hunt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_end |=> !chan_busy);

    // R8
    par_needs_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_par_err |-> byte_vld);

    // R2
    busy_rise_on_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chan_busy) |-> ($past(bit_vld) && !$past(pkt_end)));

    // R5
    pol_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bit_vld) |-> $stable(pol_inv));

    // R12
    byte_keeps_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |-> chan_busy);

endmodule

bind line_pkt_framer pkfr_checker u_pkfr_chk (.*);

// File: tb/line_pkt_framer_bench.sv
module line_pkt_framer_bench;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_vld = 1'b0;
    logic       bit_in = 1'b0;
    logic       pkt_end = 1'b0;
    logic [7:0] byte_data;
    logic       byte_vld, byte_par_err, frame_err, chan_busy, pol_inv;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    line_pkt_framer u_line_pkt_framer (
        .clk          (clk),
        .rst_n        (rst_n),
        .bit_vld      (bit_vld),
        .bit_in       (bit_in),
        .pkt_end      (pkt_end),
        .byte_data    (byte_data),
        .byte_vld     (byte_vld),
        .byte_par_err (byte_par_err),
        .frame_err    (frame_err),
        .chan_busy    (chan_busy),
        .pol_inv      (pol_inv)
    );

    // reference model state, derived from the requirements
    int       m_state = 0;
    int       m_run = 0;
    bit       m_prev = 0, m_have = 0;
    bit [3:0] m_win = 0;
    int       m_ws = 0;
    bit       m_inv = 0;
    int       m_idx = 0;
    bit [7:0] m_sh = 0;
    bit       m_par = 0;
    bit       e_bv = 0, e_pe = 0, e_fe = 0;
    bit [7:0] e_byte = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic m_bit(input bit b);
        int rn;
        bit d;
        rn = (m_have && b != m_prev) ? ((m_run == 12) ? 12 : m_run + 1) : 1;
        m_win = {m_win[2:0], b};
        e_bv = 0; e_fe = 0; e_pe = 0;
        case (m_state)
            0: if (rn >= 4) m_state = 1;
            1: begin
                if (rn == 1) m_state = 0;
                else if (rn >= 12) begin m_state = 2; m_ws = 0; end
            end
            2: begin
                if (m_win == 4'b1100) begin
                    m_state = 3; m_inv = 0; m_idx = 0; m_par = 0;
                end else if (m_win == 4'b0011) begin
                    m_state = 3; m_inv = 1; m_idx = 0; m_par = 0;
                end else if (m_ws == 15) m_state = 0;
                else m_ws++;
            end
            default: begin
                d = b ^ m_inv;
                if (m_idx < 8) begin
                    m_sh = {m_sh[6:0], d}; m_par ^= d;
                end else if (m_idx == 8) begin
                    m_par ^= d;
                end else if (!d) begin
                    e_fe = 1; m_state = 0;
                end else if (m_idx == 10) begin
                    e_bv = 1; e_byte = m_sh; e_pe = m_par; m_par = 0;
                end
                m_idx = (m_idx == 10) ? 0 : m_idx + 1;
            end
        endcase
        m_run = rn; m_prev = b; m_have = 1;
    endtask

    task automatic compare();
        chk(chan_busy == (m_state != 0), "R11 busy", chan_busy, m_state != 0);
        chk(byte_vld == e_bv, "R7 byte_vld", byte_vld, e_bv);
        chk(frame_err == e_fe, "R9 frame_err", frame_err, e_fe);
        if (m_state == 3)
            chk(pol_inv == m_inv, "R5 pol_inv", pol_inv, m_inv);
        if (e_bv) begin
            chk(byte_data == e_byte, "R7 byte_data", byte_data, e_byte);
            chk(byte_par_err == e_pe, "R8 par_err", byte_par_err, e_pe);
        end
    endtask

    task automatic send_bit(input bit b);
        bit_vld = 1'b1;
        bit_in  = b;
        m_bit(b);
        @(negedge clk);
        bit_vld = 1'b0;
        compare();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            e_bv = 0; e_fe = 0; e_pe = 0;
            compare();
        end
    endtask

    task automatic abort_pkt();
        pkt_end = 1'b1;
        m_state = 0; m_run = 0; m_have = 0;
        e_bv = 0; e_fe = 0; e_pe = 0;
        @(negedge clk);
        pkt_end = 1'b0;
        compare();
    endtask

    task automatic send_preamble(input int n, input bit first);
        for (int i = 0; i < n; i++) send_bit(first ^ i[0]);
    endtask

    task automatic send_sync(input bit inv);
        send_bit(1 ^ inv); send_bit(1 ^ inv); send_bit(0 ^ inv); send_bit(0 ^ inv);
    endtask

    task automatic send_cw(input bit [7:0] v, input bit flip_par, input int bad_stop, input bit inv);
        for (int i = 7; i >= 0; i--) send_bit(v[i] ^ inv);
        send_bit((^v) ^ flip_par ^ inv);
        send_bit((bad_stop == 1) ? inv : ~inv);
        if (bad_stop != 1) send_bit((bad_stop == 2) ? inv : ~inv);
    endtask

    function automatic bit odd_byte(input bit [7:0] v);
        return ^v;
    endfunction

    initial begin
        #(CLK_PERIOD * 190000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h1D5E_0077));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(chan_busy == 0, "R1 busy", chan_busy, 0);
        chk(byte_vld == 0, "R1 byte_vld", byte_vld, 0);
        chk(frame_err == 0, "R1 frame_err", frame_err, 0);
        chk(pol_inv == 0, "R1 pol_inv", pol_inv, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: three alternating bits are not enough, the fourth raises busy
        send_bit(1); send_bit(0); send_bit(1);
        chk(chan_busy == 0, "R2 short run", chan_busy, 0);
        send_bit(0);
        chk(chan_busy == 1, "R2 run of four", chan_busy, 1);
        // R3: repeated bit drops back
        send_bit(0);
        chk(chan_busy == 0, "R3 repeat bit", chan_busy, 0);

        // R4: 1100 after a short run opens no frame
        idle(2);
        send_preamble(6, 1);
        send_sync(0);
        send_cw(8'hA5, 0, 0, 0);
        chk(chan_busy == 0, "R4 no early sync", chan_busy, 0);

        // R7 / R12 / R8 / R9: good frame
        abort_pkt();
        send_preamble(12, 1);
        send_sync(0);
        chk(pol_inv == 0, "R5 true sync", pol_inv, 0);
        send_cw(8'hA5, 0, 0, 0);
        chk(byte_vld == 1 && byte_data == 8'hA5, "R7 first byte", byte_data, 8'hA5);
        send_cw(8'h3C, 0, 0, 0);
        chk(byte_vld == 1 && byte_data == 8'h3C, "R12 back to back", byte_data, 8'h3C);
        send_cw(8'h01, 1, 0, 0);
        chk(byte_par_err == 1, "R8 parity flip", byte_par_err, 1);
        send_cw(8'h77, 0, 1, 0);
        chk(frame_err == 1 && chan_busy == 0, "R9 bad stop", frame_err, 1);

        // R5: inverted sync
        idle(3);
        send_preamble(12, 1);
        send_sync(1);
        chk(pol_inv == 1, "R5 inverted sync", pol_inv, 1);
        send_cw(8'hC3, 0, 0, 1);
        chk(byte_vld == 1 && byte_data == 8'hC3, "R5 inverted byte", byte_data, 8'hC3);
        abort_pkt();

        // R6: sync timeout
        send_preamble(12, 1);
        send_preamble(15, 1);
        chk(chan_busy == 1, "R6 before timeout", chan_busy, 1);
        send_bit(0);
        chk(chan_busy == 0, "R6 timeout", chan_busy, 0);

        // R10: abort in DATA, run restarts
        abort_pkt();
        send_preamble(12, 1);
        send_sync(0);
        send_bit(1); send_bit(0); send_bit(1);
        abort_pkt();
        chk(chan_busy == 0, "R10 abort", chan_busy, 0);
        send_bit(0); send_bit(1); send_bit(0);
        chk(chan_busy == 0, "R10 run restarted", chan_busy, 0);
        send_bit(1);
        chk(chan_busy == 1, "R10 run of four", chan_busy, 1);
        abort_pkt();

        // random packets
        for (int p = 0; p < 500; p++) begin
            int  plen, nby, kind;
            bit  inv, first;
            plen  = int'($urandom_range(6, 22));
            first = 1'($urandom_range(0, 1));
            inv   = 1'($urandom_range(0, 1));
            nby   = int'($urandom_range(1, 4));
            send_preamble(plen, first);
            if ($urandom_range(0, 9) == 0) begin
                for (int k = 0; k < 4; k++) send_bit(1'($urandom_range(0, 1)));
            end else begin
                send_sync(inv);
            end
            for (int b = 0; b < nby; b++) begin
                bit [7:0] v;
                v    = 8'($urandom_range(0, 255));
                kind = int'($urandom_range(0, 15));
                send_cw(v, kind == 0, (kind == 1) ? 1 : ((kind == 2) ? 2 : 0), inv);
                if (odd_byte(v) && kind == 3) abort_pkt();
            end
            if ($urandom_range(0, 3) == 0) abort_pkt();
            idle(int'($urandom_range(0, 3)));
            for (int k = 0; k < int'($urandom_range(0, 6)); k++)
                send_bit(1'($urandom_range(0, 1)));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule